// File: doc/BRIEF.md
# Execute-Stage Operand Bypass with Register File

This block holds the integer register file of a five-stage pipeline and supplies the two ALU operands of the instruction that is in the execute stage. The register file has two read ports, addressed by the execute-stage source register numbers, and one write port, fed from the writeback slot.

The block keeps two result slots. The newer slot holds the instruction that left execute one cycle ago. The older slot holds the instruction that left execute two cycles ago. Each slot stores its destination register number, its write enable and its result.

For each operand, the block compares the source register number against both slot destinations. It returns the newer slot's result, the older slot's result, or the register file entry, and it reports which of the three it chose. A load's data arrives one cycle after the load leaves execute. From then on, the loaded value reaches later instructions through the older slot and then the register file. The block has no interlock for a load. Software keeps the instruction right after a load from reading the load's destination.

Top module: `fwd_regfile`

## Requirements
- R1: After reset, every register reads as zero. With no writing instruction in flight, both operand selects are 0.
- R2: Source register 0 always gives an operand of zero with select 0. An instruction that names register 0 as its destination never changes any operand.
- R3: Newer-slot forwarding. If the instruction in execute one cycle earlier had its write enable high and a nonzero destination equal to a source, that operand equals that instruction's `alu_res`, and its select is 1.
- R4: Older-slot forwarding. This applies when the instruction in execute two cycles earlier wrote the source register and the newer slot does not match. The operand then equals that instruction's result and its select is 2. The result is `alu_res` for a non-load. For a load (`ex_is_load` = 1), it is the `mem_rdata` driven in the cycle after the load was in execute.
- R5: When both slots match a source, the newer slot wins: select 1, newer result.
- R6: A slot whose write enable was low never supplies an operand, even if its destination matches.
- R7: A result from three or more cycles earlier is served from the register file with select 0. The write takes effect in the cycle the result sits in the older slot, and a read in that same cycle already sees the new value through the bypass.
- R8: The two operands are resolved independently of each other, including when both name the same register. Select encoding for each operand: 0 register file, 1 newer slot, 2 older slot. The value 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_src1 | input | AW | First source register number of the execute instruction |
| ex_src2 | input | AW | Second source register number of the execute instruction |
| ex_dst | input | AW | Destination register number of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes its destination |
| ex_is_load | input | 1 | Execute instruction is a load |
| alu_res | input | XLEN | ALU result of the execute instruction |
| mem_rdata | input | XLEN | Load data of the instruction one cycle past execute |
| op_a | output | XLEN | First ALU operand |
| op_b | output | XLEN | Second ALU operand |
| sel_a | output | 2 | Source of op_a (0 file, 1 newer, 2 older) |
| sel_b | output | 2 | Source of op_b (0 file, 1 newer, 2 older) |

## Verification
The embedded properties check on every cycle the behaviour that can be stated in terms of the ports:
- register 0 reads as zero;
- a one-cycle-old writer is returned, and it takes priority;
- a two-cycle-old writer, including load data, is returned when the newer slot does not match;
- a disabled writer is never selected;
- the select code 3 never appears.

Only the bench's scenarios show how values persist in the register file over long distances. These scenarios cover the four-deep add chain, the reset contents of all registers, and a long stream of mixed writes and loads compared against the reference model.

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   ex_src1,
  input  logic [AW-1:0]   ex_src2,
  input  logic [AW-1:0]   ex_dst,
  input  logic            ex_wen,
  input  logic            ex_is_load,
  input  logic [XLEN-1:0] alu_res,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] op_a,
  output logic [XLEN-1:0] op_b,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b
);

  logic [XLEN-1:0] rf [NREG];

  logic [AW-1:0]   new_dst, old_dst;
  logic            new_wen, old_wen, new_ld;
  logic [XLEN-1:0] new_res, old_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_wen <= 1'b0;
      old_wen <= 1'b0;
      new_ld  <= 1'b0;
      new_dst <= '0;
      old_dst <= '0;
      new_res <= '0;
      old_res <= '0;
    end else begin
      new_dst <= ex_dst;
      new_wen <= ex_wen && (ex_dst != '0);
      new_ld  <= ex_is_load;
      new_res <= alu_res;
      old_dst <= new_dst;
      old_wen <= new_wen;
      old_res <= new_ld ? mem_rdata : new_res;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (old_wen) begin
      rf[old_dst] <= old_res;
    end
  end

  logic [AW-1:0]   src [2];
  logic [XLEN-1:0] opv [2];
  logic [1:0]      sel [2];

  assign src[0] = ex_src1;
  assign src[1] = ex_src2;

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic hit_new, hit_old, nz;
    assign nz      = src[p] != '0;
    assign hit_new = nz && new_wen && (new_dst == src[p]);
    assign hit_old = nz && old_wen && (old_dst == src[p]);

    always_comb begin
      if (hit_new)      begin opv[p] = new_res;    sel[p] = 2'd1; end
      else if (hit_old) begin opv[p] = old_res;    sel[p] = 2'd2; end
      else if (nz)      begin opv[p] = rf[src[p]]; sel[p] = 2'd0; end
      else              begin opv[p] = '0;         sel[p] = 2'd0; end
    end

    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (src[p] == '0) |-> (opv[p] == '0 && sel[p] == 2'd0));

    assert_newest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ex_wen) && $past(ex_dst) == src[p] && src[p] != '0)
      |-> (opv[p] == $past(alu_res) && sel[p] == 2'd1));

    assert_older_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(ex_wen, 2) && $past(ex_dst, 2) == src[p] && src[p] != '0
       && !($past(ex_wen) && $past(ex_dst) == src[p]))
      |-> (sel[p] == 2'd2 &&
           opv[p] == ($past(ex_is_load, 2) ? $past(mem_rdata) : $past(alu_res, 2))));

    assert_disabled_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ex_wen)) |-> (sel[p] != 2'd1));

    assert_sel_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sel[p] != 2'd3);
  end

  assign op_a  = opv[0];
  assign op_b  = opv[1];
  assign sel_a = sel[0];
  assign sel_b = sel[1];

endmodule

// File: tb/tb_fwd_regfile.sv
module tb_fwd_regfile;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] ex_src1 = '0, ex_src2 = '0, ex_dst = '0;
  logic ex_wen = 1'b0, ex_is_load = 1'b0;
  logic [XLEN-1:0] alu_res = '0, mem_rdata = '0;
  logic [XLEN-1:0] op_a, op_b;
  logic [1:0] sel_a, sel_b;

  always #10 clk = ~clk;

  fwd_regfile #(.XLEN(XLEN), .NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .ex_src1(ex_src1), .ex_src2(ex_src2),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .alu_res(alu_res), .mem_rdata(mem_rdata),
    .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b));

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [XLEN-1:0] m_rf [NREG];
  int h1_dst, h2_dst;
  bit h1_w, h2_w, h1_ld;
  logic [XLEN-1:0] h1_v, h2_v;
  int lcg = 12345;

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int s);
    if (s == 0) return "R2";
    if (h1_w && h1_dst == s && h2_w && h2_dst == s) return "R5";
    if (h1_w && h1_dst == s) return "R3";
    if (h2_w && h2_dst == s) return "R4";
    return "R7";
  endfunction

  task automatic expect_op(int s, output logic [XLEN-1:0] v, output logic [1:0] sl);
    if (s == 0) begin v = '0; sl = 0; end
    else if (h1_w && h1_dst == s) begin v = h1_v; sl = 1; end
    else if (h2_w && h2_dst == s) begin v = h2_v; sl = 2; end
    else begin v = m_rf[s]; sl = 0; end
  endtask

  task automatic step(int s1, int s2, int d, bit w, bit ld, logic [XLEN-1:0] res,
                      logic [XLEN-1:0] md, string extra);
    logic [XLEN-1:0] ea, eb;
    logic [1:0] sa, sb;
    @(negedge clk);
    ex_src1 = s1[AW-1:0]; ex_src2 = s2[AW-1:0]; ex_dst = d[AW-1:0];
    ex_wen = w; ex_is_load = ld; alu_res = res; mem_rdata = md;
    #2;
    expect_op(s1, ea, sa);
    expect_op(s2, eb, sb);
    chk({tag_of(s1), " op_a R8 ", extra}, op_a, ea);
    chk({tag_of(s1), " sel_a ", extra}, {30'd0, sel_a}, {30'd0, sa});
    chk({tag_of(s2), " op_b R8 ", extra}, op_b, eb);
    chk({tag_of(s2), " sel_b ", extra}, {30'd0, sel_b}, {30'd0, sb});
    if (h2_w && h2_dst != 0) m_rf[h2_dst] = h2_v;
    h2_dst = h1_dst; h2_w = h1_w;
    h2_v = h1_ld ? md : h1_v;
    h1_dst = d; h1_w = w && (d != 0); h1_ld = ld; h1_v = res;
  endtask

  function automatic int rnd();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) & 32'h7fffffff;
  endfunction

  initial begin
    #4000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) m_rf[i] = '0;
    h1_w = 0; h2_w = 0; h1_ld = 0; h1_dst = 0; h2_dst = 0; h1_v = '0; h2_v = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset contents of every register
    for (int i = 0; i < NREG; i++) step(i, NREG - 1 - i, 0, 0, 0, 32'hdead0000 + i, 0, "R1 reset");

    // add chain: r5 feeds the next four instructions (R3, R4, R7)
    step(1, 2, 5, 1, 0, 32'h0000_1234, 0, "chain head");
    step(5, 4, 3, 1, 0, 32'h1111_0001, 0, "chain 1");
    step(5, 7, 6, 1, 0, 32'h1111_0002, 0, "chain 2");
    step(8, 5, 8, 1, 0, 32'h1111_0003, 0, "chain 3");
    step(5, 5, 9, 1, 0, 32'h1111_0004, 0, "chain 4");

    // R5: back-to-back writes of r10
    step(0, 0, 10, 1, 0, 32'haaaa_0001, 0, "R5 first");
    step(0, 0, 10, 1, 0, 32'haaaa_0002, 0, "R5 second");
    step(10, 10, 0, 0, 0, 0, 0, "R5 read");

    // R6: disabled writer of r11
    step(0, 0, 11, 0, 0, 32'hbad0_0011, 0, "R6 off");
    step(11, 11, 0, 0, 0, 0, 0, "R6 read");
    step(11, 0, 0, 0, 0, 0, 0, "R6 read2");

    // R2: destination zero never forwarded
    step(0, 0, 0, 1, 0, 32'hbad0_0000, 0, "R2 write");
    step(0, 0, 0, 0, 0, 0, 0, "R2 read");

    // R4 load: r12 loaded, gap, then used
    step(3, 4, 12, 1, 1, 32'h0000_0040, 0, "R4 load");
    step(1, 2, 13, 1, 0, 32'h0000_0077, 32'hc0de_beef, "R4 gap");
    step(12, 13, 14, 1, 0, 32'h0000_0099, 0, "R4 use");
    step(12, 12, 0, 0, 0, 0, 0, "R7 after load");

    // mixed stream against the reference model
    for (int k = 0; k < 600; k++) begin
      int s1, s2, d;
      bit w, ld;
      s1 = rnd() % 8; s2 = rnd() % 8; d = rnd() % 8;
      w = (rnd() % 4) != 0;
      ld = (rnd() % 4) == 0;
      if (h1_ld && h1_w) begin
        if (s1 == h1_dst) s1 = 0;
        if (s2 == h1_dst) s2 = 0;
      end
      step(s1, s2, d, w, ld, rnd(), rnd(), "stream");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule